// File: doc/BRIEF.md
# Daisy-Chained Interrupt Request Node

This block is the interrupt logic of one peripheral on a multiplexed, asynchronous backplane bus. The device's local logic sets an enable bit and a pending-request bit. The node raises its request line whenever both bits are set. The processor answers with an acknowledge transaction: it asserts the data-in strobe with the sync line low, and it starts the acknowledge grant at the head of a positional daisy chain. Each node either keeps the grant or hands it to the next node. A node keeps the grant only if it was requesting when the grant reached it. The node that keeps the grant drives its fixed vector onto the 16 data lines, asserts reply and clears its pending request.

The bus strobes and the incoming grant are asynchronous to the local clock, so they pass through a synchronizer before any decision is made. The keep/hand-on decision is captured once, when the synchronized grant first appears, and it holds until the grant goes away. A request that appears part way through a transaction therefore cannot disturb the chain. The outgoing grant is gated by the raw incoming grant, so it falls as soon as the upstream grant falls. All bus pins here are active-high logic levels; inversion and open-collector drivers sit outside the block. The vector output has no back-pressure: `dal_oe` marks it valid, and the node holds it until the processor drops both the strobe and the grant. The processor is the only consumer.

Top module: `irq_chain_node`

## Requirements
- R1: `irq_out` is high exactly when the enable bit and the request bit are both set. The enable bit is loaded from `ie_wdata` when `ie_we` is high. A `req_set` pulse sets the request bit. Either write shows on `irq_out` one clock after the edge that samples it.
- R2: An acknowledge transaction is `iak_in`=1 and `din_in`=1 with `sync_in`=0. A node holding the grant drives no vector and no reply while `sync_in` is high. It responds once `sync_in` falls with `din_in` still high.
- R3: If the node is requesting when the synchronized grant first appears, it keeps the grant and never raises `iak_out` in that transaction. If it is not requesting, it hands the grant on through `iak_out`. `iak_out` and `dal_oe` are never high together.
- R4: The node that keeps the grant raises `dal_oe` with `dal_out` equal to the `VECTOR` parameter. It raises `rply_out` one clock later with the vector still driven. Both stay high until `din_in` and `iak_in` are both seen low.
- R5: The request bit clears at the edge where `rply_out` rises. The enable bit is unchanged.
- R6: The keep/hand-on decision holds for the whole transaction. A node that is handing the grant on, and gets a new request before the grant falls, keeps handing it on and keeps its request pending.
- R7: `iak_out` is low in any instant in which `iak_in` is low, with no clock delay.
- R8: Reset (`rst_n` low) or a clock with `bus_init` high clears the enable bit, the request bit and the handshake state. `bus_init` wins over a `req_set` in the same clock.
- R9: A `req_set` in the same clock as the acknowledge clear of R5 wins, so the request stays pending.
- R10: When several nodes are chained, only the requesting node nearest the head of the chain replies to a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init | input | 1 | Bus initialize, synchronous clear |
| ie_we | input | 1 | Write strobe for the enable bit |
| ie_wdata | input | 1 | New enable bit value |
| req_set | input | 1 | Pulse that sets the request bit |
| sync_in | input | 1 | Bus sync line (asynchronous) |
| din_in | input | 1 | Bus data-in strobe (asynchronous) |
| iak_in | input | 1 | Grant from the upstream neighbour (asynchronous) |
| irq_out | output | 1 | Interrupt request line |
| iak_out | output | 1 | Grant to the downstream neighbour |
| rply_out | output | 1 | Reply line |
| dal_out | output | 16 | Vector on the data lines |
| dal_oe | output | 1 | Data line drive enable (vector valid) |

## Verification
Two functions can meet in one clock: the local logic raising a new request, and the acknowledge clearing the old one as reply rises. The bench provokes this by watching `dal_oe`. In the clock in which the vector first appears, it pulses `req_set`, so the set and the clear are sampled at the same edge. It then checks that the node still requests, and that a second transaction is taken by the same node. A second collision is also tested: `bus_init` and `req_set` in the same clock, where `bus_init` must win.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned BUS_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_TAKE,
    ST_VEC,
    ST_REPLY
  } ack_state_e;
endpackage

// File: rtl/irq_chain_sync.sv
module irq_chain_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_chain_regs.sv
module irq_chain_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic ie_we,
  input  logic ie_wdata,
  input  logic req_set,
  input  logic req_clr,
  output logic ie_q,
  output logic req_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (init) begin
      ie_q <= 1'b0;
    end else if (ie_we) begin
      ie_q <= ie_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (init) begin
      req_q <= 1'b0;
    end else if (req_set) begin
      req_q <= 1'b1;
    end else if (req_clr) begin
      req_q <= 1'b0;
    end
  end

  assign irq = ie_q & req_q;

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init) |-> (!ie_q && !req_q)); // R8

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ie_we || req_set)); // R1

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_set && req_clr && !init) |-> req_q); // R9
endmodule

// File: rtl/irq_chain_fsm.sv
module irq_chain_fsm
  import irq_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic iak_s,
  input  logic din_s,
  input  logic sync_s,
  input  logic requesting,
  output logic pass_q,
  output logic drive_vec,
  output logic rply,
  output logic req_clr
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (iak_s) state_d = requesting ? ST_TAKE : ST_PASS;
      ST_PASS:  if (!iak_s) state_d = ST_IDLE;
      ST_TAKE: begin
        if (!iak_s)                  state_d = ST_IDLE;
        else if (din_s && !sync_s)   state_d = ST_VEC;
      end
      ST_VEC:   state_d = ST_REPLY;
      ST_REPLY: if (!din_s && !iak_s) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= ST_IDLE;
    else if (init) state_q <= ST_IDLE;
    else           state_q <= state_d;
  end

  assign pass_q    = (state_q == ST_PASS);
  assign drive_vec = (state_q == ST_VEC) || (state_q == ST_REPLY);
  assign rply      = (state_q == ST_REPLY);
  assign req_clr   = (state_q == ST_VEC);

  AST_REPLY_AFTER_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rply) |-> $past(drive_vec)); // R4

  AST_PASS_WHEN_IDLE_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && iak_s && !requesting && !init) |=> pass_q); // R3

  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q && iak_s && !init) |=> (pass_q && !drive_vec)); // R6

  AST_NO_VEC_DURING_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAKE && sync_s) |=> !drive_vec); // R2
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node #(
  parameter logic [15:0] VECTOR      = 16'h0040,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_init,
  input  logic        ie_we,
  input  logic        ie_wdata,
  input  logic        req_set,
  input  logic        sync_in,
  input  logic        din_in,
  input  logic        iak_in,
  output logic        irq_out,
  output logic        iak_out,
  output logic        rply_out,
  output logic [15:0] dal_out,
  output logic        dal_oe
);
  import irq_chain_pkg::*;

  localparam int unsigned NUM_ASYNC = 3;

  logic [NUM_ASYNC-1:0] async_raw, async_s;
  logic ie_q, req_q, irq;
  logic pass_q, drive_vec, rply, req_clr;

  assign async_raw = {iak_in, din_in, sync_in};

  irq_chain_sync #(
    .WIDTH (NUM_ASYNC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (async_raw),
    .q    (async_s)
  );

  irq_chain_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (bus_init),
    .ie_we   (ie_we),
    .ie_wdata(ie_wdata),
    .req_set (req_set),
    .req_clr (req_clr),
    .ie_q    (ie_q),
    .req_q   (req_q),
    .irq     (irq)
  );

  irq_chain_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (bus_init),
    .iak_s     (async_s[2]),
    .din_s     (async_s[1]),
    .sync_s    (async_s[0]),
    .requesting(irq),
    .pass_q    (pass_q),
    .drive_vec (drive_vec),
    .rply      (rply),
    .req_clr   (req_clr)
  );

  assign irq_out  = irq;
  assign iak_out  = pass_q & iak_in;
  assign rply_out = rply;
  assign dal_oe   = drive_vec;
  assign dal_out  = drive_vec ? VECTOR : '0;

  AST_EXCLUSIVE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(iak_out && dal_oe)); // R3

  AST_REQ_GONE_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rply_out) && !$past(req_set)) |-> (!irq_out && $stable(ie_q))); // R5
endmodule

// File: tb/irq_chain_node_bench.sv
`timescale 1ns/1ps
module irq_chain_node_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_init = 1'b0;
  logic sync_l = 1'b0, din_l = 1'b0, iak_l = 1'b0;
  logic [2:0] ie_we = '0, ie_wdata = '0, req_set = '0;
  logic [2:0] irq, iako, rply, oe;
  logic [15:0] dal0, dal1, dal2;

  int errors = 0;
  int checks = 0;
  int q_dev[$];
  int q_vec[$];

  always #4 clk = ~clk;

  irq_chain_node #(.VECTOR(16'h0040)) u_irq_chain_node (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .ie_we(ie_we[0]), .ie_wdata(ie_wdata[0]), .req_set(req_set[0]),
    .sync_in(sync_l), .din_in(din_l), .iak_in(iak_l),
    .irq_out(irq[0]), .iak_out(iako[0]), .rply_out(rply[0]),
    .dal_out(dal0), .dal_oe(oe[0]));

  irq_chain_node #(.VECTOR(16'h0044)) u_irq_chain_node_1 (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .ie_we(ie_we[1]), .ie_wdata(ie_wdata[1]), .req_set(req_set[1]),
    .sync_in(sync_l), .din_in(din_l), .iak_in(iako[0]),
    .irq_out(irq[1]), .iak_out(iako[1]), .rply_out(rply[1]),
    .dal_out(dal1), .dal_oe(oe[1]));

  irq_chain_node #(.VECTOR(16'h0048)) u_irq_chain_node_2 (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .ie_we(ie_we[2]), .ie_wdata(ie_wdata[2]), .req_set(req_set[2]),
    .sync_in(sync_l), .din_in(din_l), .iak_in(iako[1]),
    .irq_out(irq[2]), .iak_out(iako[2]), .rply_out(rply[2]),
    .dal_out(dal2), .dal_oe(oe[2]));

  function automatic int vec_of(input int dev);
    return 32'h40 + 4 * dev;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard whenever a reply rises anywhere on the chain
  logic rply_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((rply != 0) && !rply_prev) begin
        int who;
        int bus_val;
        who = rply[0] ? 0 : (rply[1] ? 1 : 2);
        bus_val = (oe[0] ? dal0 : 16'h0) | (oe[1] ? dal1 : 16'h0) | (oe[2] ? dal2 : 16'h0);
        check($countones(rply) == 1, "R10 single replier", $countones(rply), 1);
        if (q_dev.size() == 0) begin
          check(1'b0, "R10 unexpected reply", who, -1);
        end else begin
          int exp_dev;
          int exp_vec;
          exp_dev = q_dev.pop_front();
          exp_vec = q_vec.pop_front();
          check(who == exp_dev, "R10 replying node", who, exp_dev);
          check(bus_val == exp_vec, "R4 vector with reply", bus_val, exp_vec);
        end
      end
      rply_prev = (rply != 0);
    end
  end

  task automatic set_ie(input int dev, input bit val);
    @(negedge clk);
    ie_we[dev] = 1'b1; ie_wdata[dev] = val;
    @(negedge clk);
    ie_we[dev] = 1'b0;
  endtask

  task automatic pulse_req(input int dev);
    @(negedge clk);
    req_set[dev] = 1'b1;
    @(negedge clk);
    req_set[dev] = 1'b0;
  endtask

  // One acknowledge transaction. exp_dev < 0 means nobody should answer.
  task automatic ack_cycle(input int exp_dev, input string tag,
                           input bit set_at_vec, input int late_dev);
    int waited;
    if (exp_dev >= 0) begin
      q_dev.push_back(exp_dev);
      q_vec.push_back(vec_of(exp_dev));
    end
    @(negedge clk);
    iak_l = 1'b1; din_l = 1'b1; sync_l = 1'b0;
    waited = 0;
    if (late_dev >= 0) begin
      repeat (5) @(negedge clk);
      waited = 5;
      req_set[late_dev] = 1'b1;
      @(negedge clk);
      req_set[late_dev] = 1'b0;
    end
    while (oe == 0 && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    if (set_at_vec && exp_dev >= 0) begin
      req_set[exp_dev] = 1'b1;
      @(negedge clk);
      req_set[exp_dev] = 1'b0;
    end
    while (rply == 0 && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    if (exp_dev >= 0) begin
      check(rply != 0, tag, rply, 1);
      check(iako[exp_dev] == 1'b0, "R3 keeper does not pass", iako[exp_dev], 0);
    end else begin
      check(rply == 0 && oe == 0, tag, rply, 0);
      check(iako[2] == 1'b1, "R3 grant passed to chain end", iako[2], 1);
    end
    @(negedge clk);
    iak_l = 1'b0; din_l = 1'b0;
    repeat (10) @(negedge clk);
    check(rply == 0 && oe == 0, "R4 reply released", rply, 0);
    check(q_dev.size() == 0, "R10 scoreboard drained", q_dev.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 0 && rply == 0 && iako == 0 && oe == 0, "R8 reset state",
          {irq, rply, iako, oe}, 0);

    // R1: request alone, then enable
    pulse_req(0);
    check(irq[0] == 1'b0, "R1 request without enable", irq[0], 0);
    set_ie(0, 1'b1);
    check(irq[0] == 1'b1, "R1 enable and request", irq[0], 1);

    // R3/R5: node 0 takes, clears request, keeps enable
    ack_cycle(0, "R3 head node takes", 1'b0, -1);
    check(irq[0] == 1'b0, "R5 request cleared", irq[0], 0);
    pulse_req(0);
    check(irq[0] == 1'b1, "R5 enable kept", irq[0], 1);

    // R10: nodes 0 and 2 requesting, node 0 first, then node 2
    set_ie(2, 1'b1);
    pulse_req(2);
    set_ie(1, 1'b1);
    check(irq == 3'b101, "R1 two requesters", irq, 5);
    ack_cycle(0, "R10 nearest requester replies", 1'b0, -1);
    check(irq == 3'b100, "R10 far node still pending", irq, 4);
    ack_cycle(2, "R10 far node replies", 1'b0, -1);
    check(irq == 3'b000, "R5 far node cleared", irq, 0);

    // R6: node 1 requesting; node 0 gets a request while passing
    pulse_req(1);
    ack_cycle(1, "R6 decision held at node 0", 1'b0, 0);
    check(irq == 3'b001, "R6 late request stays pending", irq, 1);
    ack_cycle(0, "R6 late request served next", 1'b0, -1);

    // R2: strobe with sync high does not complete
    pulse_req(1);
    @(negedge clk);
    iak_l = 1'b1; din_l = 1'b1; sync_l = 1'b1;
    repeat (25) @(negedge clk);
    check(rply == 0 && oe == 0, "R2 no response during sync", {rply, oe}, 0);
    q_dev.push_back(1);
    q_vec.push_back(vec_of(1));
    sync_l = 1'b0;
    repeat (25) @(negedge clk);
    check(rply[1] == 1'b1, "R2 response after sync falls", rply[1], 1);
    iak_l = 1'b0; din_l = 1'b0;
    repeat (10) @(negedge clk);
    check(q_dev.size() == 0, "R2 scoreboard drained", q_dev.size(), 0);

    // R9: new request coincides with acknowledge clear
    pulse_req(2);
    ack_cycle(2, "R9 node 2 replies", 1'b1, -1);
    check(irq[2] == 1'b1, "R9 coincident set wins", irq[2], 1);
    ack_cycle(2, "R9 second request served", 1'b0, -1);
    check(irq[2] == 1'b0, "R9 cleared afterwards", irq[2], 0);

    // R7: nobody requests; grant runs to chain end and drops at once
    ack_cycle(-1, "R3 nobody replies", 1'b0, -1);
    @(negedge clk);
    iak_l = 1'b1; din_l = 1'b1;
    repeat (20) @(negedge clk);
    check(iako == 3'b111, "R7 grant passed along", iako, 7);
    iak_l = 1'b0;
    #1;
    check(iako == 3'b000, "R7 grant drops without delay", iako, 0);
    din_l = 1'b0;
    repeat (10) @(negedge clk);

    // R8: initialize beats a coincident set, and clears enable
    pulse_req(2);
    check(irq[2] == 1'b1, "R8 precondition", irq[2], 1);
    @(negedge clk);
    bus_init = 1'b1; req_set[2] = 1'b1;
    @(negedge clk);
    bus_init = 1'b0; req_set[2] = 1'b0;
    check(irq == 3'b000, "R8 init clears all", irq, 0);
    pulse_req(2);
    check(irq[2] == 1'b0, "R8 enable cleared by init", irq[2], 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule